// File: doc/BRIEF.md
# Switch Configuration Register Target on a Two-Wire Serial Bus

This block is the configuration front end of a display-port switch. It is a target on the two-wire serial bus (I2C), with SCL and SDA each brought in as a level and SDA driven out as an open-drain pull-low enable. The bus master reaches five byte-wide indexed registers through it. Three of them hold read/write settings for port selection, priority, equalization, output drive and switch timing. One returns a fixed identification byte. One mixes four read/write control bits with the live hot-plug levels of the three output ports. Every register field is brought out as a plain control pin for the port selector and the re-driver.

A write transfer carries the index byte first and then data bytes. A read transfer returns bytes from the current index. The index advances by one after every data byte written and after every byte handed out on a read, so a write that carries only an index, followed by a read transfer, reads from that index. The bus lines are sampled against the system clock through a two-stage synchronizer. A START or STOP condition is recognised in every state and returns the byte engine to a known point. There is no stream interface and no back-pressure: the target never stretches SCL, so the master's clock alone paces every byte.

Top module: `swcfg_i2c_target`

## Requirements
- R1: The target acknowledges only the 7-bit address {1,0,1,1,strap_a2,strap_a1,1} followed by the R/W bit (1 = read, 0 = write). Any other address gets no ACK and changes no register.
- R2: In a write transfer every byte is acknowledged. The first byte after the address sets the index, and each later byte is written to the index, which then advances by one.
- R3: A read transfer returns bytes starting at the current index and advancing by one per byte. The target keeps sending while the master ACKs and stops after a master NACK.
- R4: Index 0 resets to 0x00 and drives standby (bit 7), port_sel (bits 6:5), prio_code (bits 4:2) and hdmi_in (bit 1). Bit 0 is not stored and reads 0.
- R5: Index 1 resets to 0x00. All eight bits are read/write and drive eq_code (7:5), time_scale (4:3), tsel_t3 (2), tsel_t4 (1) and tsel_t1 (0).
- R6: Index 2 resets to 0x00 and drives term_dbl (7), preemph (6:4), swing (3:2) and slew_up (1). Bit 0 is not stored and reads 0.
- R7: Index 3 always reads 0x51. Writes to it are acknowledged and have no effect.
- R8: Index 4 bits 7:4 reset to 0, are read/write and drive hpd_inv, ddc_passive, sw_immediate and tsel_t2. Bits 3:1 read the live hpd_lvl[2], hpd_lvl[1] and hpd_lvl[0]. Bit 0 reads 0.
- R9: A write to an index above 4 is acknowledged and ignored, and a read from such an index returns 0x00.
- R10: A STOP in the middle of a byte abandons that byte without writing it. A START in the middle of a byte restarts address reception.
- R11: SDA is pulled low only during the target's ACK bit and the zero bits of read data. It is released after every STOP and while in reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe | output | 1 | 1 pulls SDA low |
| strap_a2 | input | 1 | Address strap, address bit 2 |
| strap_a1 | input | 1 | Address strap, address bit 1 |
| hpd_lvl | input | 3 | Live hot-plug levels, bit 0 = port 1 |
| standby | output | 1 | Standby request |
| port_sel | output | 2 | Manual port select code |
| prio_code | output | 3 | Automatic priority order code |
| hdmi_in | output | 1 | Input type select, 1 = HDMI |
| eq_code | output | 3 | Equalization code |
| time_scale | output | 2 | Switch timing scale code |
| tsel_t3 | output | 1 | Output-off window select |
| tsel_t4 | output | 1 | Power-down delay select |
| tsel_t1 | output | 1 | IRQ pulse width select |
| term_dbl | output | 1 | Output termination mode |
| preemph | output | 3 | Pre-emphasis code |
| swing | output | 2 | Output swing code |
| slew_up | output | 1 | Slew adjust |
| hpd_inv | output | 1 | Invert the hot-plug output to the source |
| ddc_passive | output | 1 | Port-3 DDC path: 1 = passive switch, 0 = buffer |
| sw_immediate | output | 1 | Manual switching without the output-off window |
| tsel_t2 | output | 1 | Deassert-delay select |

## Verification
The bench first writes all-ones and mixed bit patterns across consecutive indexes, then reads them back in one burst. This separates stored bits from the reserved bits that always read zero, and shows whether the index advances across the read-only identification byte and into the live status byte. Writes that cross from index 3 into 4 and beyond 4, followed by reads from there, separate acknowledged-but-ignored writes from writes that take effect. Transfers cut by a STOP or a repeated START partway through a byte, together with a change of the straps, show that only a complete byte sent to the strapped address changes anything.

// File: rtl/swcfg_pkg.sv
package swcfg_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WR,
    ST_WR_ACK,
    ST_RD,
    ST_RD_ACK
  } tgt_state_t;

  localparam int IDX_CFG   = 0;
  localparam int IDX_RX    = 1;
  localparam int IDX_TX    = 2;
  localparam int IDX_ID    = 3;
  localparam int IDX_HPD   = 4;
  localparam logic [3:0] ADDR_FIXED = 4'b1011;
  localparam logic [7:0] ID_BYTE    = 8'h51;
endpackage

// File: rtl/swcfg_line_sync.sv
module swcfg_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic level,
  output logic rise,
  output logic fall
);
  // one extra stage keeps the previous synchronized level for edge detection
  logic [STAGES:0] pipe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe <= '1;
    else        pipe <= {pipe[STAGES-1:0], line_i};
  end

  assign level = pipe[STAGES-1];
  assign rise  = pipe[STAGES-1] & ~pipe[STAGES];
  assign fall  = ~pipe[STAGES-1] & pipe[STAGES];
endmodule

// File: rtl/swcfg_byte_engine.sv
module swcfg_byte_engine
  import swcfg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_lvl,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       sda_lvl,
  input  logic       sda_rise,
  input  logic       sda_fall,
  input  logic [6:0] dev_addr,
  input  logic [7:0] rd_data,
  output logic       sda_oe,
  output logic       idx_set,
  output logic       data_wr,
  output logic       rd_fetch,
  output logic [7:0] wr_byte
);
  tgt_state_t state;
  logic [7:0] shreg;
  logic [3:0] cnt;
  logic       rw;
  logic       first;
  logic       mack;
  logic       start_ev, stop_ev;

  assign start_ev = sda_fall & scl_lvl;
  assign stop_ev  = sda_rise & scl_lvl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      shreg    <= '0;
      cnt      <= '0;
      rw       <= 1'b0;
      first    <= 1'b0;
      mack     <= 1'b0;
      sda_oe   <= 1'b0;
      idx_set  <= 1'b0;
      data_wr  <= 1'b0;
      rd_fetch <= 1'b0;
      wr_byte  <= '0;
    end else begin
      idx_set  <= 1'b0;
      data_wr  <= 1'b0;
      rd_fetch <= 1'b0;
      if (stop_ev) begin
        state  <= ST_IDLE;
        sda_oe <= 1'b0;
      end else if (start_ev) begin
        state  <= ST_ADDR;
        cnt    <= '0;
        sda_oe <= 1'b0;
      end else begin
        unique case (state)
          ST_ADDR, ST_WR: begin
            if (scl_rise && cnt != 4'd8) begin
              shreg <= {shreg[6:0], sda_lvl};
              cnt   <= cnt + 4'd1;
            end else if (scl_fall && cnt == 4'd8) begin
              if (state == ST_ADDR) begin
                if (shreg[7:1] == dev_addr) begin
                  sda_oe <= 1'b1;
                  rw     <= shreg[0];
                  first  <= 1'b1;
                  state  <= ST_ADDR_ACK;
                end else begin
                  state  <= ST_IDLE;
                end
              end else begin
                sda_oe  <= 1'b1;
                wr_byte <= shreg;
                first   <= 1'b0;
                if (first) idx_set <= 1'b1;
                else       data_wr <= 1'b1;
                state   <= ST_WR_ACK;
              end
            end
          end
          ST_ADDR_ACK: begin
            if (scl_fall) begin
              cnt <= '0;
              if (rw) begin
                shreg    <= rd_data;
                sda_oe   <= ~rd_data[7];
                rd_fetch <= 1'b1;
                state    <= ST_RD;
              end else begin
                sda_oe   <= 1'b0;
                state    <= ST_WR;
              end
            end
          end
          ST_WR_ACK: begin
            if (scl_fall) begin
              sda_oe <= 1'b0;
              cnt    <= '0;
              state  <= ST_WR;
            end
          end
          ST_RD: begin
            if (scl_fall) begin
              if (cnt == 4'd7) begin
                sda_oe <= 1'b0;
                state  <= ST_RD_ACK;
              end else begin
                shreg  <= {shreg[6:0], 1'b0};
                sda_oe <= ~shreg[6];
                cnt    <= cnt + 4'd1;
              end
            end
          end
          ST_RD_ACK: begin
            if (scl_rise) begin
              mack <= ~sda_lvl;
            end else if (scl_fall) begin
              if (mack) begin
                shreg    <= rd_data;
                sda_oe   <= ~rd_data[7];
                rd_fetch <= 1'b1;
                cnt      <= '0;
                state    <= ST_RD;
              end else begin
                state    <= ST_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R11: the line is only pulled during an ACK slot or a read data bit
  a_r11_drive_window: assert property (@(posedge clk) disable iff (!rst_n)
    sda_oe |-> (state inside {ST_ADDR_ACK, ST_WR_ACK, ST_RD}));

  // R10 / R11: a STOP always releases the line and idles the engine
  a_r10_stop_idles: assert property (@(posedge clk) disable iff (!rst_n)
    stop_ev |=> (state == ST_IDLE && !sda_oe));

  // R1: a foreign address is never acknowledged
  a_r1_foreign_no_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ADDR && scl_fall && cnt == 4'd8 && shreg[7:1] != dev_addr)
      |=> (!sda_oe && state == ST_IDLE));

  // R2: every data byte of a write gets an ACK slot
  a_r2_byte_acked: assert property (@(posedge clk) disable iff (!rst_n)
    (idx_set || data_wr) |-> (sda_oe && state == ST_WR_ACK));
endmodule

// File: rtl/swcfg_reg_file.sv
module swcfg_reg_file
  import swcfg_pkg::*;
#(
  parameter int         IDX_W   = 8,
  parameter logic [7:0] ID_VAL  = ID_BYTE,
  parameter int         HPD_N   = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             idx_set,
  input  logic             data_wr,
  input  logic             rd_fetch,
  input  logic [7:0]       wr_byte,
  input  logic [HPD_N-1:0] hpd_lvl,
  output logic [7:0]       rd_data,
  output logic [7:1]       cfg_q,
  output logic [7:0]       rx_q,
  output logic [7:1]       tx_q,
  output logic [7:4]       hpd_ctl_q
);
  localparam logic [IDX_W-1:0] I_CFG = IDX_W'(IDX_CFG);
  localparam logic [IDX_W-1:0] I_RX  = IDX_W'(IDX_RX);
  localparam logic [IDX_W-1:0] I_TX  = IDX_W'(IDX_TX);
  localparam logic [IDX_W-1:0] I_ID  = IDX_W'(IDX_ID);
  localparam logic [IDX_W-1:0] I_HPD = IDX_W'(IDX_HPD);
  localparam int PAD_W = 3 - HPD_N;

  logic [IDX_W-1:0] idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx       <= '0;
      cfg_q     <= '0;
      rx_q      <= '0;
      tx_q      <= '0;
      hpd_ctl_q <= '0;
    end else if (idx_set) begin
      idx <= IDX_W'(wr_byte);
    end else if (data_wr) begin
      idx <= idx + IDX_W'(1);
      if (idx == I_CFG)      cfg_q     <= wr_byte[7:1];
      else if (idx == I_RX)  rx_q      <= wr_byte;
      else if (idx == I_TX)  tx_q      <= wr_byte[7:1];
      else if (idx == I_HPD) hpd_ctl_q <= wr_byte[7:4];
    end else if (rd_fetch) begin
      idx <= idx + IDX_W'(1);
    end
  end

  generate
    if (PAD_W > 0) begin : g_pad
      logic [2:0] hpd_w;
      assign hpd_w = {{PAD_W{1'b0}}, hpd_lvl};
      always_comb begin
        if (idx == I_CFG)      rd_data = {cfg_q, 1'b0};
        else if (idx == I_RX)  rd_data = rx_q;
        else if (idx == I_TX)  rd_data = {tx_q, 1'b0};
        else if (idx == I_ID)  rd_data = ID_VAL;
        else if (idx == I_HPD) rd_data = {hpd_ctl_q, hpd_w, 1'b0};
        else                   rd_data = 8'h00;
      end
    end else begin : g_full
      always_comb begin
        if (idx == I_CFG)      rd_data = {cfg_q, 1'b0};
        else if (idx == I_RX)  rd_data = rx_q;
        else if (idx == I_TX)  rd_data = {tx_q, 1'b0};
        else if (idx == I_ID)  rd_data = ID_VAL;
        else if (idx == I_HPD) rd_data = {hpd_ctl_q, hpd_lvl[2:0], 1'b0};
        else                   rd_data = 8'h00;
      end
    end
  endgenerate

  // R7 / R9: writes to the identification byte or beyond index 4 change nothing
  a_r9_ignored_write: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && (idx == I_ID || idx > I_HPD))
      |=> ({cfg_q, rx_q, tx_q, hpd_ctl_q} == $past({cfg_q, rx_q, tx_q, hpd_ctl_q})));

  // R2: the index advances after each data byte written
  a_r2_idx_step: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && !idx_set) |=> (idx == $past(idx) + IDX_W'(1)));

  // R3: the index advances after each byte handed out for a read
  a_r3_fetch_step: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_fetch && !idx_set && !data_wr) |=> (idx == $past(idx) + IDX_W'(1)));
endmodule

// File: rtl/swcfg_i2c_target.sv
module swcfg_i2c_target
  import swcfg_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int IDX_W       = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  input  logic       strap_a2,
  input  logic       strap_a1,
  input  logic [2:0] hpd_lvl,
  output logic       standby,
  output logic [1:0] port_sel,
  output logic [2:0] prio_code,
  output logic       hdmi_in,
  output logic [2:0] eq_code,
  output logic [1:0] time_scale,
  output logic       tsel_t3,
  output logic       tsel_t4,
  output logic       tsel_t1,
  output logic       term_dbl,
  output logic [2:0] preemph,
  output logic [1:0] swing,
  output logic       slew_up,
  output logic       hpd_inv,
  output logic       ddc_passive,
  output logic       sw_immediate,
  output logic       tsel_t2
);
  localparam int LINES = 2;
  localparam int L_SCL = 0;
  localparam int L_SDA = 1;

  logic [LINES-1:0] line_in, line_lvl, line_rise, line_fall;
  assign line_in = {sda_i, scl_i};

  generate
    for (genvar g = 0; g < LINES; g++) begin : g_sync
      swcfg_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .line_i(line_in[g]),
        .level (line_lvl[g]),
        .rise  (line_rise[g]),
        .fall  (line_fall[g])
      );
    end
  endgenerate

  logic [6:0] dev_addr;
  assign dev_addr = {ADDR_FIXED, strap_a2, strap_a1, 1'b1};

  logic       idx_set, data_wr, rd_fetch;
  logic [7:0] wr_byte, rd_data;
  logic [7:1] cfg_q, tx_q;
  logic [7:0] rx_q;
  logic [7:4] hpd_ctl_q;

  swcfg_byte_engine u_eng (
    .clk     (clk),
    .rst_n   (rst_n),
    .scl_lvl (line_lvl[L_SCL]),
    .scl_rise(line_rise[L_SCL]),
    .scl_fall(line_fall[L_SCL]),
    .sda_lvl (line_lvl[L_SDA]),
    .sda_rise(line_rise[L_SDA]),
    .sda_fall(line_fall[L_SDA]),
    .dev_addr(dev_addr),
    .rd_data (rd_data),
    .sda_oe  (sda_oe),
    .idx_set (idx_set),
    .data_wr (data_wr),
    .rd_fetch(rd_fetch),
    .wr_byte (wr_byte)
  );

  swcfg_reg_file #(.IDX_W(IDX_W), .ID_VAL(ID_BYTE), .HPD_N(3)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .idx_set  (idx_set),
    .data_wr  (data_wr),
    .rd_fetch (rd_fetch),
    .wr_byte  (wr_byte),
    .hpd_lvl  (hpd_lvl),
    .rd_data  (rd_data),
    .cfg_q    (cfg_q),
    .rx_q     (rx_q),
    .tx_q     (tx_q),
    .hpd_ctl_q(hpd_ctl_q)
  );

  assign {standby, port_sel, prio_code, hdmi_in}           = cfg_q;
  assign {eq_code, time_scale, tsel_t3, tsel_t4, tsel_t1}  = rx_q;
  assign {term_dbl, preemph, swing, slew_up}               = tx_q;
  assign {hpd_inv, ddc_passive, sw_immediate, tsel_t2}     = hpd_ctl_q;
endmodule

// File: tb/tb_swcfg_i2c_target.sv
module tb_swcfg_i2c_target;
  typedef logic [7:0] bq_t[$];

  localparam int H = 16;
  localparam int Q = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m_low = 1'b0;
  logic strap_a2 = 1'b1, strap_a1 = 1'b0;
  logic [2:0] hpd_lvl = 3'b000;
  logic sda_oe, sda_line;
  logic standby, hdmi_in, tsel_t3, tsel_t4, tsel_t1, term_dbl, slew_up;
  logic hpd_inv, ddc_passive, sw_immediate, tsel_t2;
  logic [1:0] port_sel, time_scale, swing;
  logic [2:0] prio_code, eq_code, preemph;

  always #5 clk = ~clk;
  assign sda_line = ~(sda_oe | sda_m_low);

  swcfg_i2c_target dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
    .strap_a2(strap_a2), .strap_a1(strap_a1), .hpd_lvl(hpd_lvl),
    .standby(standby), .port_sel(port_sel), .prio_code(prio_code), .hdmi_in(hdmi_in),
    .eq_code(eq_code), .time_scale(time_scale), .tsel_t3(tsel_t3), .tsel_t4(tsel_t4),
    .tsel_t1(tsel_t1), .term_dbl(term_dbl), .preemph(preemph), .swing(swing),
    .slew_up(slew_up), .hpd_inv(hpd_inv), .ddc_passive(ddc_passive),
    .sw_immediate(sw_immediate), .tsel_t2(tsel_t2)
  );

  int total = 0, bad = 0;
  bit done = 1'b0;
  logic [7:0] exp_q[$], obs_q[$];
  string      tag_q[$];

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  // scoreboard monitor: compares read bytes as the bus produces them
  initial begin
    forever begin
      @(negedge clk);
      while (obs_q.size() > 0 && exp_q.size() > 0) begin
        check(tag_q.pop_front(), obs_q.pop_front(), exp_q.pop_front());
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  function automatic logic [7:0] out_cfg();  return {standby, port_sel, prio_code, hdmi_in, 1'b0}; endfunction
  function automatic logic [7:0] out_rx();   return {eq_code, time_scale, tsel_t3, tsel_t4, tsel_t1}; endfunction
  function automatic logic [7:0] out_tx();   return {term_dbl, preemph, swing, slew_up, 1'b0}; endfunction
  function automatic logic [7:0] out_hctl(); return {hpd_inv, ddc_passive, sw_immediate, tsel_t2, 4'h0}; endfunction

  task automatic wclk(int n); repeat (n) @(negedge clk); endtask

  task automatic bus_start();
    sda_m_low = 1'b1; wclk(H); scl_m = 1'b0;
  endtask
  task automatic bus_rstart();
    wclk(Q); sda_m_low = 1'b0; wclk(Q); scl_m = 1'b1; wclk(H);
    sda_m_low = 1'b1; wclk(H); scl_m = 1'b0;
  endtask
  task automatic bus_stop();
    wclk(Q); sda_m_low = 1'b1; wclk(Q); scl_m = 1'b1; wclk(H);
    sda_m_low = 1'b0; wclk(H);
  endtask
  task automatic put_bit(logic b);
    wclk(Q); sda_m_low = ~b; wclk(Q); scl_m = 1'b1; wclk(H); scl_m = 1'b0;
  endtask
  task automatic put_byte(logic [7:0] b, output logic acked);
    for (int i = 7; i >= 0; i--) put_bit(b[i]);
    wclk(Q); sda_m_low = 1'b0; wclk(Q); scl_m = 1'b1; wclk(Q);
    acked = ~sda_line; wclk(Q); scl_m = 1'b0;
  endtask
  task automatic get_byte(logic master_ack, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      wclk(Q); sda_m_low = 1'b0; wclk(Q); scl_m = 1'b1; wclk(Q);
      b[i] = sda_line; wclk(Q); scl_m = 1'b0;
    end
    put_bit(~master_ack);
  endtask

  // write: index then data; returns number of ACKed bytes including address
  task automatic wr_txn(logic [6:0] a, logic [7:0] idx, bq_t d, output int acks);
    logic ak;
    acks = 0;
    bus_start();
    put_byte({a, 1'b0}, ak); acks += int'(ak);
    if (ak) begin
      put_byte(idx, ak); acks += int'(ak);
      foreach (d[i]) begin put_byte(d[i], ak); acks += int'(ak); end
    end
    bus_stop();
  endtask

  // read from the current index; expected bytes go to the scoreboard first
  task automatic rd_txn(logic [6:0] a, string req, bq_t exp);
    logic ak;
    logic [7:0] b;
    foreach (exp[i]) begin exp_q.push_back(exp[i]); tag_q.push_back(req); end
    bus_start();
    put_byte({a, 1'b1}, ak);
    check({req, " address ACK"}, {7'd0, ak}, 8'd1);
    foreach (exp[i]) begin
      get_byte(i != exp.size() - 1, b);
      obs_q.push_back(b);
    end
    bus_stop();
    wclk(4);
    check({req, " SDA released after read (R11)"}, {7'd0, sda_oe}, 8'd0);
  endtask

  localparam logic [6:0] A_ON  = 7'b1011101;
  localparam logic [6:0] A_OFF = 7'b1011011;

  initial begin
    int acks;
    logic ak;
    wclk(5); rst_n = 1'b1; wclk(5);

    // reset state: R4 R5 R6 R8 R11
    check("R4 reset index0 fields", out_cfg(), 8'h00);
    check("R5 reset index1 fields", out_rx(), 8'h00);
    check("R6 reset index2 fields", out_tx(), 8'h00);
    check("R8 reset index4 control bits", out_hctl(), 8'h00);
    check("R11 SDA idle after reset", {7'd0, sda_oe}, 8'd0);

    // R1: foreign address is not acknowledged and writes nothing
    wr_txn(A_OFF, 8'h00, '{8'hFF}, acks);
    check("R1 foreign address ACK count", 8'(acks), 8'd0);
    check("R1 foreign write left index0", out_cfg(), 8'h00);

    // R2 R4 R5 R6: burst write from index 0
    wr_txn(A_ON, 8'h00, '{8'hFF, 8'hA5, 8'hFF}, acks);
    check("R2 every byte ACKed", 8'(acks), 8'd5);
    check("R4 index0 fields, bit0 reserved", out_cfg(), 8'hFE);
    check("R5 index1 all bits", out_rx(), 8'hA5);
    check("R6 index2 fields, bit0 reserved", out_tx(), 8'hFE);

    // R3 R7 R8: burst read across all indexes, live hpd 3'b101 -> bits 3:1 = 101
    hpd_lvl = 3'b101;
    wr_txn(A_ON, 8'h00, '{}, acks);
    rd_txn(A_ON, "R3 R7 R8 burst read", '{8'hFE, 8'hA5, 8'hFE, 8'h51, 8'h0A});

    // R7 R8: write across read-only index 3 into index 4
    wr_txn(A_ON, 8'h03, '{8'h00, 8'hF3}, acks);
    check("R7 write to index3 ACKed", 8'(acks), 8'd4);
    check("R8 index4 control bits", out_hctl(), 8'hF0);
    hpd_lvl = 3'b010;
    wr_txn(A_ON, 8'h03, '{}, acks);
    rd_txn(A_ON, "R7 R8 id and live status", '{8'h51, 8'hF4});

    // R9: writes above index 4 ACKed and ignored, reads give zero
    wr_txn(A_ON, 8'h05, '{8'h77, 8'h88}, acks);
    check("R9 high-index writes ACKed", 8'(acks), 8'd4);
    check("R9 index0 unchanged", out_cfg(), 8'hFE);
    check("R9 index1 unchanged", out_rx(), 8'hA5);
    check("R9 index2 unchanged", out_tx(), 8'hFE);
    check("R9 index4 unchanged", out_hctl(), 8'hF0);
    wr_txn(A_ON, 8'h04, '{}, acks);
    rd_txn(A_ON, "R9 read past index4", '{8'hF4, 8'h00, 8'h00});

    // R10: STOP in mid byte abandons it
    bus_start();
    put_byte({A_ON, 1'b0}, ak);
    put_byte(8'h01, ak);
    for (int i = 0; i < 4; i++) put_bit(1'b0);
    bus_stop();
    check("R10 STOP mid-byte leaves index1", out_rx(), 8'hA5);

    // R10: START in mid byte restarts address reception
    bus_start();
    put_byte({A_ON, 1'b0}, ak);
    put_byte(8'h01, ak);
    for (int i = 0; i < 3; i++) put_bit(1'b1);
    bus_rstart();
    put_byte({A_ON, 1'b0}, ak);
    check("R10 address ACK after repeated START", {7'd0, ak}, 8'd1);
    put_byte(8'h01, ak);
    put_byte(8'h3C, ak);
    bus_stop();
    check("R10 write after repeated START", out_rx(), 8'h3C);

    // R3: read continues from index set by an index-only write
    wr_txn(A_ON, 8'h02, '{}, acks);
    rd_txn(A_ON, "R3 read at current index", '{8'hFE});

    // R1: new straps select the other address
    strap_a2 = 1'b0; strap_a1 = 1'b1;
    wr_txn(A_ON, 8'h01, '{8'h99}, acks);
    check("R1 old address ignored after strap change", 8'(acks), 8'd0);
    wr_txn(A_OFF, 8'h01, '{8'h11}, acks);
    check("R1 new strapped address ACKed", 8'(acks), 8'd3);
    check("R1 write via new address", out_rx(), 8'h11);
    check("R11 SDA released after STOP", {7'd0, sda_oe}, 8'd0);

    wclk(20);
    check("R3 scoreboard drained", 8'(exp_q.size()), 8'd0);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule